// File: doc/BRIEF.md
# Programmable Delay Sequencer for a Line Buffer

This block sits beside a fixed-length line memory whose write and read sides share one clock. The memory has a write pointer and a read pointer, each of which advances on every enabled clock, wraps at the end of the line and returns to address zero on a reset strobe. The sequencer drives those four strobes (write reset, read reset, write enable, read enable). Its aim is that a word written in one cycle comes out of the memory exactly `n` cycles later, where `n` is any value up to the line length. No shift register is involved: the memory's fixed length is turned into a variable delay purely by the timing of pointer resets and read enable.

A start request samples the requested delay, the strategy code, the speed grade and the word/byte organisation. It then restarts the internal counters from zero. Three strategies are selectable:

- **Ring:** both pointers are reset together every `n` cycles.
- **Staggered reset:** the read reset is issued `n` cycles after the write reset, and both pointers then run over the whole line.
- **Read hold-off:** both pointers are reset together, and read enable is then held off for `n` cycles.

A delay outside the legal window is clamped to the nearest bound and raises a sticky error flag. A `delay_valid` output tells downstream logic when the memory output has started to carry real delayed data.

Top module: `ldly_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first start request, all six outputs are low.
- R2: Cycle 0 is the cycle after the clock edge that samples `start` high. With strategy code 0 (ring), `wr_rst` and `rd_rst` are both high in cycles 0, n, 2n, … and low otherwise. `wr_en` and `rd_en` are high in every cycle.
- R3: With strategy code 1 (staggered reset), `wr_rst` is high only in cycle 0 and `rd_rst` only in cycle n. `wr_en` and `rd_en` are high in every cycle.
- R4: With strategy code 2 or 3 (read hold-off), `wr_rst` and `rd_rst` are both high only in cycle 0. `wr_en` is always high. `rd_en` is low in cycles 0 to n-1 and high from cycle n on.
- R5: `delay_valid` is low in cycles 0 to n-1 after a start and high from cycle n until the next start.
- R6: The legal window for n has a lower bound of 21 when `fast_grade` is 1 and 15 when it is 0. Its upper bound is LINE_WORDS (default 5048) when `byte_mode` is 0 and 2·LINE_WORDS (10096) when it is 1. Any n inside the window, including both bounds, is used unchanged.
- R7: A requested n below the window is replaced by the lower bound; one above it is replaced by the upper bound.
- R8: `range_err` goes high in cycle 0 of a start whose request was out of the window. It then stays high through later starts and is cleared only by `rst_n`.
- R9: Changes to `n_req`, `strat_sel`, `fast_grade` and `byte_mode` take effect only at the next start. A start during a run restarts the sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for the sequencer and both sides of the buffer |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request; samples the configuration and restarts the sequence |
| n_req | input | NW (14) | Requested delay in cycles |
| strat_sel | input | 2 | Strategy: 0 ring, 1 staggered reset, 2/3 read hold-off |
| fast_grade | input | 1 | 1 selects the faster memory grade (higher minimum delay) |
| byte_mode | input | 1 | 1 selects the byte organisation (doubled line length) |
| wr_rst | output | 1 | Write pointer reset strobe |
| rd_rst | output | 1 | Read pointer reset strobe |
| wr_en | output | 1 | Write enable |
| rd_en | output | 1 | Read enable |
| delay_valid | output | 1 | High once n cycles have elapsed since the last start |
| range_err | output | 1 | Sticky flag for a clamped delay request |

## Verification
The hardest situations to reach are the far ends of the window. The upper clamp and the longest legal byte-mode delay only show their read reset, or their read-enable release, thousands of cycles after the start. The stimulus therefore starts those runs and follows them cycle by cycle until just past cycle n. Each start is issued on top of a running sequence, and the configuration inputs are scrambled immediately after the sampling edge. This shows both that a restart truly begins again at cycle 0 and that later configuration changes are held off. A second reset at the end confirms that the sticky error flag clears only there.

// File: rtl/ldly_pkg.sv
package ldly_pkg;

    typedef enum logic [1:0] {
        STRAT_RING    = 2'd0,
        STRAT_STAGGER = 2'd1,
        STRAT_HOLDOFF = 2'd2
    } strat_e;

    function automatic strat_e decode_strat(input logic [1:0] code);
        case (code)
            2'd0:    return STRAT_RING;
            2'd1:    return STRAT_STAGGER;
            default: return STRAT_HOLDOFF;
        endcase
    endfunction

endpackage

// File: rtl/ldly_clamp.sv
module ldly_clamp #(
    parameter int NW         = 14,
    parameter int LINE_WORDS = 5048,
    parameter int MIN_FAST   = 21,
    parameter int MIN_SLOW   = 15
) (
    input  logic [NW-1:0] n_req,
    input  logic          fast_grade,
    input  logic          byte_mode,
    output logic [NW-1:0] n_eff,
    output logic          out_of_range
);
    localparam logic [NW-1:0] LO_FAST = NW'(MIN_FAST);
    localparam logic [NW-1:0] LO_SLOW = NW'(MIN_SLOW);
    localparam logic [NW-1:0] HI_WORD = NW'(LINE_WORDS);
    localparam logic [NW-1:0] HI_BYTE = NW'(2 * LINE_WORDS);

    logic [NW-1:0] lo_bound;
    logic [NW-1:0] hi_bound;

    always_comb begin
        lo_bound     = fast_grade ? LO_FAST : LO_SLOW;
        hi_bound     = byte_mode  ? HI_BYTE : HI_WORD;
        out_of_range = 1'b0;
        n_eff        = n_req;
        if (n_req < lo_bound) begin
            n_eff        = lo_bound;
            out_of_range = 1'b1;
        end else if (n_req > hi_bound) begin
            n_eff        = hi_bound;
            out_of_range = 1'b1;
        end
    end
endmodule

// File: rtl/ldly_counter.sv
module ldly_counter #(
    parameter int NW   = 14,
    parameter bit WRAP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [NW-1:0] limit,
    output logic [NW-1:0] count
);
    logic [NW-1:0] count_d;
    logic [NW-1:0] count_q;

    generate
        if (WRAP) begin : g_wrap
            always_comb begin
                count_d = count_q;
                if (clr)
                    count_d = '0;
                else if (adv)
                    count_d = (count_q == limit - NW'(1)) ? '0 : count_q + NW'(1);
            end
        end else begin : g_sat
            always_comb begin
                count_d = count_q;
                if (clr)
                    count_d = '0;
                else if (adv && (count_q != limit))
                    count_d = count_q + NW'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/ldly_ctrl.sv
module ldly_ctrl #(
    parameter int LINE_WORDS = 5048,
    parameter int MIN_FAST   = 21,
    parameter int MIN_SLOW   = 15,
    parameter int NW         = $clog2(2 * LINE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] n_req,
    input  logic [1:0]    strat_sel,
    input  logic          fast_grade,
    input  logic          byte_mode,
    output logic          wr_rst,
    output logic          rd_rst,
    output logic          wr_en,
    output logic          rd_en,
    output logic          delay_valid,
    output logic          range_err
);
    import ldly_pkg::*;

    typedef struct packed {
        logic          run;
        strat_e        mode;
        logic [NW-1:0] n;
        logic          done;
        logic          err;
    } state_t;

    state_t        state_d;
    state_t        state_q;
    logic [NW-1:0] n_eff;
    logic          oor;
    logic [NW-1:0] elapsed;
    logic [NW-1:0] phase;
    logic          reached;

    ldly_clamp #(
        .NW(NW), .LINE_WORDS(LINE_WORDS), .MIN_FAST(MIN_FAST), .MIN_SLOW(MIN_SLOW)
    ) u_clamp (
        .n_req(n_req), .fast_grade(fast_grade), .byte_mode(byte_mode),
        .n_eff(n_eff), .out_of_range(oor)
    );

    ldly_counter #(.NW(NW), .WRAP(1'b0)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .clr(start), .adv(state_q.run),
        .limit(state_q.n), .count(elapsed)
    );

    ldly_counter #(.NW(NW), .WRAP(1'b1)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(start), .adv(state_q.run),
        .limit(state_q.n), .count(phase)
    );

    assign reached = state_q.run && (elapsed == state_q.n);

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.run  = 1'b1;
            state_d.mode = decode_strat(strat_sel);
            state_d.n    = n_eff;
            state_d.done = 1'b0;
            state_d.err  = state_q.err | oor;
        end else if (reached) begin
            state_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{run: 1'b0, mode: STRAT_RING, n: '0, done: 1'b0, err: 1'b0};
        else        state_q <= state_d;
    end

    always_comb begin
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        wr_en  = state_q.run;
        rd_en  = state_q.run;
        if (state_q.run) begin
            case (state_q.mode)
                STRAT_RING: begin
                    wr_rst = (phase == '0);
                    rd_rst = (phase == '0);
                end
                STRAT_STAGGER: begin
                    wr_rst = (elapsed == '0);
                    rd_rst = reached && !state_q.done;
                end
                default: begin
                    wr_rst = (elapsed == '0);
                    rd_rst = (elapsed == '0);
                    rd_en  = reached;
                end
            endcase
        end
    end

    assign delay_valid = reached;
    assign range_err   = state_q.err;
endmodule

// File: rtl/ldly_ctrl_chk.sv
module ldly_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic wr_rst,
    input logic rd_rst,
    input logic wr_en,
    input logic rd_en,
    input logic delay_valid,
    input logic range_err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !(wr_rst || rd_rst || rd_en || delay_valid));

    assert_start_wr_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> wr_rst);

    assert_valid_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !delay_valid);

    assert_valid_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_valid && !start) |=> delay_valid);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    assert_write_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        delay_valid |-> (wr_en && rd_en));
endmodule

bind ldly_ctrl ldly_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_rst(wr_rst), .rd_rst(rd_rst),
    .wr_en(wr_en), .rd_en(rd_en), .delay_valid(delay_valid), .range_err(range_err)
);

// File: tb/sim_ldly_ctrl.sv
`timescale 1ns/1ps
module sim_ldly_ctrl;
    localparam int NW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] n_req = '0;
    logic [1:0]    strat_sel = 2'd0;
    logic          fast_grade = 1'b0;
    logic          byte_mode = 1'b0;
    logic wr_rst, rd_rst, wr_en, rd_en, delay_valid, range_err;

    int checks = 0;
    int errors = 0;
    logic  err_model = 1'b0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    ldly_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .n_req(n_req), .strat_sel(strat_sel),
        .fast_grade(fast_grade), .byte_mode(byte_mode), .wr_rst(wr_rst), .rd_rst(rd_rst),
        .wr_en(wr_en), .rd_en(rd_en), .delay_valid(delay_valid), .range_err(range_err)
    );

    function automatic logic [5:0] observed();
        return {range_err, delay_valid, rd_en, wr_en, rd_rst, wr_rst};
    endfunction

    // monitor: pops one expected vector per cycle, 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (observed() !== e) begin
                errors++;
                $display("FAIL %s: {err,valid,rd_en,wr_en,rd_rst,wr_rst} actual=%b expected=%b at %0t",
                         t, observed(), e, $time);
            end
        end
    end

    task automatic idle_check(input int cycles, input string tag);
        @(negedge clk);
        for (int k = 0; k < cycles; k++) begin
            exp_q.push_back({err_model, 5'b00000});
            tag_q.push_back(tag);
        end
        wait (exp_q.size() == 0);
    endtask

    // drive one start, predict every cycle, then scramble the configuration (R9)
    task automatic run_case(input int n, input int strat, input bit fast, input bit bmode,
                            input int cycles, input string tag);
        int lo, hi, ne;
        lo = fast ? 21 : 15;
        hi = bmode ? 10096 : 5048;
        ne = (n < lo) ? lo : (n > hi) ? hi : n;
        if (n != ne) err_model = 1'b1;
        @(negedge clk);
        start = 1'b1; n_req = NW'(n); strat_sel = 2'(strat);
        fast_grade = fast; byte_mode = bmode;
        for (int k = 0; k < cycles; k++) begin
            logic wr_r, rd_r, rd_e, v;
            v = (k >= ne);
            if (strat == 0) begin
                wr_r = (k % ne == 0); rd_r = wr_r; rd_e = 1'b1;
            end else if (strat == 1) begin
                wr_r = (k == 0); rd_r = (k == ne); rd_e = 1'b1;
            end else begin
                wr_r = (k == 0); rd_r = (k == 0); rd_e = v;
            end
            exp_q.push_back({err_model, v, rd_e, 1'b1, rd_r, wr_r});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        start = 1'b0; n_req = NW'(77); strat_sel = 2'(strat ^ 1);
        fast_grade = ~fast; byte_mode = ~bmode;
        wait (exp_q.size() == 0);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #35;
        checks++;
        if (observed() !== 6'b0) begin
            errors++;
            $display("FAIL R1: during reset actual=%b expected=000000", observed());
        end
        @(negedge clk); rst_n = 1'b1;
        idle_check(8, "R1 idle before start");
        run_case(30, 0, 1'b1, 1'b0, 100, "R2 ring n=30");
        run_case(40, 1, 1'b0, 1'b0, 120, "R3 stagger n=40");
        run_case(25, 2, 1'b1, 1'b0, 80, "R4 holdoff code2 n=25");
        run_case(15, 3, 1'b0, 1'b0, 40, "R4 holdoff code3 n=15 (R6 low bound)");
        run_case(21, 0, 1'b1, 1'b0, 70, "R6 ring fast low bound n=21");
        run_case(20, 0, 1'b1, 1'b0, 70, "R7 clamp n=20 to 21 / R8 err");
        run_case(5, 1, 1'b0, 1'b0, 40, "R7 clamp n=5 to 15 / R8 sticky");
        run_case(16000, 2, 1'b0, 1'b0, 5060, "R7 clamp high to 5048 R4");
        run_case(10096, 1, 1'b1, 1'b1, 10110, "R6 byte full line stagger");
        run_case(6000, 0, 1'b0, 1'b1, 12010, "R6 byte ring n=6000 R5");
        run_case(33, 1, 1'b1, 1'b0, 80, "R9 restart mid-run");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        err_model = 1'b0;
        idle_check(5, "R8 err cleared by reset / R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule